// File: doc/BRIEF.md
# CAN Controller Interrupt Aggregator

This block holds the control register of a CAN controller and merges all of the controller's interrupt sources onto one request line for the system interrupt controller. The protocol engine sends plain single-cycle strobes: bus-off, error-warning, frame received correctly, frame sent correctly, an update of the 3-bit last-error code, and receive or transmit events for each message object. Every source is held in a sticky pending flag until software clears it.

The sources fall into two classes, each with its own enable in the control register. The error class covers bus-off and warning. The status-change class covers receive-OK, transmit-OK and a change of the last-error code. The receive-OK flag is set for every valid frame, whether or not a message object takes that frame. Each message-object event is kept only when that object's own receive or transmit enable is set. A global enable gates the registered request output. An identifier register names the source with the highest priority.

Software uses a small synchronous register port with eight 8-bit addresses to program the control and bit-timing registers, to read state, and to clear pending flags. The bit-timing register accepts writes only while the configuration-change enable is set.

Top module: `can_irq_hub`

## Requirements
- R1: After a synchronous reset, the control register reads 0x01 (initialization mode, every enable clear), the bit-timing register reads 0x00, and the status pending, object pending, identifier and `irq` are all zero.
- R2: A write to address 0 updates control bits 6 (configuration-change enable), 3 (error enable), 2 (status-change enable), 1 (global enable) and 0 (init, also driven on `init_mode`). Bits 7, 5 and 4 ignore writes and read 0.
- R3: A write to address 6 (bit timing, driven on `timing_cfg`) takes effect only while control bit 6 is 1. At any other time the write is ignored.
- R4: Status bits 3 (warning) and 4 (bus-off) of address 1 raise `irq` only while control bits 3 and 1 are both 1.
- R5: Status bits 0 (receive-OK), 1 (transmit-OK) and 2 (last-error-code change) of address 1 raise `irq` only while control bits 2 and 1 are both 1.
- R6: Every `evt_rx_ok` strobe sets status bit 0, independently of any message-object event or enable.
- R7: On a `lec_upd` strobe, status bit 2 is set only if `lec_code` differs from the stored code. The stored code then takes the new value and reads back at address 7, bits 2:0.
- R8: Object k's pending bit (address 3, bit k) is set by `obj_rx_evt[k]` when bit k of address 4 is 1, or by `obj_tx_evt[k]` when bit k of address 5 is 1. Otherwise the event is dropped.
- R9: `irq` is registered and rises one clock after a gated pending flag appears. It stays low while control bit 1 is 0.
- R10: Pending flags stay set until software writes 1 to their bit at address 1 or 3. Writing 0 has no effect, and an event in the same cycle as its clear leaves the flag set.
- R11: The identifier at address 2 reads 1 when an enabled status-class or error-class flag is pending. Otherwise it reads k+2 for the lowest pending object k, and 0 when nothing is pending.
- R12: `reg_rdata` is registered and shows, one clock later, the register selected by `reg_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| evt_bus_off | input | 1 | Bus-off strobe |
| evt_warn | input | 1 | Error-warning strobe |
| evt_rx_ok | input | 1 | Valid frame received strobe |
| evt_tx_ok | input | 1 | Frame transmitted strobe |
| lec_upd | input | 1 | Last-error code update strobe |
| lec_code | input | 3 | New last-error code |
| obj_rx_evt | input | NUM_OBJ | Per-object receive events |
| obj_tx_evt | input | NUM_OBJ | Per-object transmit events |
| irq | output | 1 | Registered interrupt request |
| timing_cfg | output | 8 | Bit-timing register value |
| init_mode | output | 1 | Control init bit |

## Verification
Each of the five status sources is pulsed under all eight combinations of the error, status-change and global enables. This separates the two gating classes from each other and from the global gate. Every object then meets every mix of receive and transmit events and enables, which separates the receive path from the transmit path. All sixteen object pending patterns, with and without a status flag, test the identifier priority. Last-error-code updates with repeated and changed codes, partial clears, and clears that collide with events exercise change detection and stickiness.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT   = 3'd1;
  localparam logic [ADDR_W-1:0] A_IDENT  = 3'd2;
  localparam logic [ADDR_W-1:0] A_OPEND  = 3'd3;
  localparam logic [ADDR_W-1:0] A_ORXEN  = 3'd4;
  localparam logic [ADDR_W-1:0] A_OTXEN  = 3'd5;
  localparam logic [ADDR_W-1:0] A_TIMING = 3'd6;
  localparam logic [ADDR_W-1:0] A_LEC    = 3'd7;

  localparam int CB_CCE  = 6;
  localparam int CB_EIE  = 3;
  localparam int CB_SIE  = 2;
  localparam int CB_IE   = 1;
  localparam int CB_INIT = 0;
  localparam logic [REG_W-1:0] CTRL_WMASK = 8'h4F;
  localparam logic [REG_W-1:0] CTRL_RST   = 8'h01;

  localparam int ST_RX   = 0;
  localparam int ST_TX   = 1;
  localparam int ST_LEC  = 2;
  localparam int ST_WARN = 3;
  localparam int ST_BOFF = 4;
  localparam int ST_N    = 5;
  localparam int LEC_W   = 3;
endpackage

// File: rtl/can_ctrl_regs.sv
module can_ctrl_regs
  import can_irq_pkg::*;
#(
  parameter logic [REG_W-1:0] TIMING_RST = 8'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  ctrl_q,
  output logic [REG_W-1:0]  timing_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= CTRL_RST;
      timing_q <= TIMING_RST;
    end else if (wr_en) begin
      if (addr == A_CTRL) ctrl_q <= wdata & CTRL_WMASK;
      if (addr == A_TIMING && ctrl_q[CB_CCE]) timing_q <= wdata;
    end
  end

  assert_timing_locked_R3: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q[CB_CCE] |=> $stable(timing_q));
endmodule

// File: rtl/can_stat_flags.sv
module can_stat_flags
  import can_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             evt_rx,
  input  logic             evt_tx,
  input  logic             evt_warn,
  input  logic             evt_boff,
  input  logic             lec_upd,
  input  logic [LEC_W-1:0] lec_val,
  input  logic             clr_en,
  input  logic [ST_N-1:0]  clr_mask,
  output logic [ST_N-1:0]  pend_q,
  output logic [LEC_W-1:0] lec_q
);
  logic            lec_chg;
  logic [ST_N-1:0] set_v;
  logic [ST_N-1:0] clr_v;

  always_comb begin
    lec_chg = lec_upd && (lec_val != lec_q);
    set_v = '0;
    set_v[ST_RX]   = evt_rx;
    set_v[ST_TX]   = evt_tx;
    set_v[ST_LEC]  = lec_chg;
    set_v[ST_WARN] = evt_warn;
    set_v[ST_BOFF] = evt_boff;
    clr_v = clr_en ? clr_mask : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      lec_q  <= '0;
    end else begin
      pend_q <= (pend_q & ~clr_v) | set_v;
      if (lec_upd) lec_q <= lec_val;
    end
  end

  assert_lec_flag_R7: assert property (@(posedge clk) disable iff (rst)
    (lec_upd && lec_val != lec_q) |=> pend_q[ST_LEC]);
  assert_lec_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (lec_upd && lec_val == lec_q && !pend_q[ST_LEC]) |=> !pend_q[ST_LEC]);
  assert_rx_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (pend_q[ST_RX] && !(clr_en && clr_mask[ST_RX])) |=> pend_q[ST_RX]);
  assert_rx_every_frame_R6: assert property (@(posedge clk) disable iff (rst)
    evt_rx |=> pend_q[ST_RX]);
endmodule

// File: rtl/can_obj_flags.sv
module can_obj_flags
  import can_irq_pkg::*;
#(
  parameter int NUM_OBJ = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic [NUM_OBJ-1:0] rx_evt,
  input  logic [NUM_OBJ-1:0] tx_evt,
  output logic [NUM_OBJ-1:0] pend_q,
  output logic [NUM_OBJ-1:0] rx_en_q,
  output logic [NUM_OBJ-1:0] tx_en_q
);
  logic wr_pend, wr_rxen, wr_txen;

  assign wr_pend = wr_en && (addr == A_OPEND);
  assign wr_rxen = wr_en && (addr == A_ORXEN);
  assign wr_txen = wr_en && (addr == A_OTXEN);

  for (genvar g = 0; g < NUM_OBJ; g++) begin : g_obj
    logic hit;
    assign hit = (rx_evt[g] && rx_en_q[g]) || (tx_evt[g] && tx_en_q[g]);

    always_ff @(posedge clk) begin
      if (rst) begin
        pend_q[g]  <= 1'b0;
        rx_en_q[g] <= 1'b0;
        tx_en_q[g] <= 1'b0;
      end else begin
        if (hit) pend_q[g] <= 1'b1;
        else if (wr_pend && wdata[g]) pend_q[g] <= 1'b0;
        if (wr_rxen) rx_en_q[g] <= wdata[g];
        if (wr_txen) tx_en_q[g] <= wdata[g];
      end
    end

    assert_obj_gate_R8: assert property (@(posedge clk) disable iff (rst)
      $rose(pend_q[g]) |-> $past((rx_evt[g] && rx_en_q[g]) || (tx_evt[g] && tx_en_q[g])));
  end
endmodule

// File: rtl/can_irq_hub.sv
module can_irq_hub
  import can_irq_pkg::*;
#(
  parameter int NUM_OBJ = 4,
  parameter logic [REG_W-1:0] TIMING_RST = 8'h00
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  input  logic               evt_bus_off,
  input  logic               evt_warn,
  input  logic               evt_rx_ok,
  input  logic               evt_tx_ok,
  input  logic               lec_upd,
  input  logic [LEC_W-1:0]   lec_code,
  input  logic [NUM_OBJ-1:0] obj_rx_evt,
  input  logic [NUM_OBJ-1:0] obj_tx_evt,
  output logic               irq,
  output logic [REG_W-1:0]   timing_cfg,
  output logic               init_mode
);
  logic [REG_W-1:0]   ctrl_q;
  logic [ST_N-1:0]    st_pend;
  logic [LEC_W-1:0]   lec_q;
  logic [NUM_OBJ-1:0] obj_pend, obj_rxen, obj_txen;
  logic               stat_hit, any_hit;
  logic [REG_W-1:0]   ident;
  logic               irq_q;
  logic [REG_W-1:0]   rdata_q;

  can_ctrl_regs #(.TIMING_RST(TIMING_RST)) i_ctrl (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .ctrl_q(ctrl_q), .timing_q(timing_cfg)
  );

  can_stat_flags i_stat (
    .clk(clk), .rst(rst),
    .evt_rx(evt_rx_ok), .evt_tx(evt_tx_ok), .evt_warn(evt_warn), .evt_boff(evt_bus_off),
    .lec_upd(lec_upd), .lec_val(lec_code),
    .clr_en(reg_wr && reg_addr == A_STAT), .clr_mask(reg_wdata[ST_N-1:0]),
    .pend_q(st_pend), .lec_q(lec_q)
  );

  can_obj_flags #(.NUM_OBJ(NUM_OBJ)) i_obj (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rx_evt(obj_rx_evt), .tx_evt(obj_tx_evt),
    .pend_q(obj_pend), .rx_en_q(obj_rxen), .tx_en_q(obj_txen)
  );

  always_comb begin
    stat_hit = (ctrl_q[CB_SIE] && (st_pend[ST_RX] || st_pend[ST_TX] || st_pend[ST_LEC]))
            || (ctrl_q[CB_EIE] && (st_pend[ST_WARN] || st_pend[ST_BOFF]));
    any_hit = stat_hit || (|obj_pend);
    ident = '0;
    for (int i = NUM_OBJ - 1; i >= 0; i--) begin
      if (obj_pend[i]) ident = REG_W'(i + 2);
    end
    if (stat_hit) ident = REG_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      irq_q <= ctrl_q[CB_IE] && any_hit;
      case (reg_addr)
        A_CTRL:   rdata_q <= ctrl_q;
        A_STAT:   rdata_q <= REG_W'(st_pend);
        A_IDENT:  rdata_q <= ident;
        A_OPEND:  rdata_q <= REG_W'(obj_pend);
        A_ORXEN:  rdata_q <= REG_W'(obj_rxen);
        A_OTXEN:  rdata_q <= REG_W'(obj_txen);
        A_TIMING: rdata_q <= timing_cfg;
        default:  rdata_q <= REG_W'(lec_q);
      endcase
    end
  end

  assign irq       = irq_q;
  assign reg_rdata = rdata_q;
  assign init_mode = ctrl_q[CB_INIT];

  assert_irq_needs_ie_R9: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q[CB_IE] |=> !irq);
  assert_irq_follows_R9: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[CB_IE] && stat_hit) |=> irq);
  assert_err_class_masked_R4: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q[CB_EIE] && !ctrl_q[CB_SIE] && obj_pend == '0) |=> !irq);
  assert_ident_nonzero_R11: assert property (@(posedge clk) disable iff (rst)
    $fell(any_hit) |=> (reg_addr != A_IDENT || $past(reg_addr) != A_IDENT || reg_rdata == '0));
endmodule

// File: tb/test_can_irq_hub.sv
`timescale 1ns/1ps
module test_can_irq_hub;
  localparam int NOBJ = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic evt_bus_off = 0, evt_warn = 0, evt_rx_ok = 0, evt_tx_ok = 0, lec_upd = 0;
  logic [2:0] lec_code = '0;
  logic [NOBJ-1:0] obj_rx_evt = '0, obj_tx_evt = '0;
  logic irq, init_mode;
  logic [7:0] timing_cfg;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  logic [2:0] lec_prev = '0;

  always #2 clk = ~clk;

  can_irq_hub #(.NUM_OBJ(NOBJ)) i_can_irq_hub (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .evt_bus_off(evt_bus_off), .evt_warn(evt_warn),
    .evt_rx_ok(evt_rx_ok), .evt_tx_ok(evt_tx_ok), .lec_upd(lec_upd), .lec_code(lec_code),
    .obj_rx_evt(obj_rx_evt), .obj_tx_evt(obj_tx_evt), .irq(irq),
    .timing_cfg(timing_cfg), .init_mode(init_mode)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  // source index: 0 rx_ok, 1 tx_ok, 2 lec change, 3 warn, 4 bus-off
  task automatic pulse_src(input int s);
    @(negedge clk);
    case (s)
      0: evt_rx_ok = 1;
      1: evt_tx_ok = 1;
      2: begin lec_code = lec_prev + 3'd1; lec_upd = 1; lec_prev = lec_prev + 3'd1; end
      3: evt_warn = 1;
      default: evt_bus_off = 1;
    endcase
    @(negedge clk);
    evt_rx_ok = 0; evt_tx_ok = 0; lec_upd = 0; evt_warn = 0; evt_bus_off = 0;
  endtask

  task automatic pulse_obj(input logic [NOBJ-1:0] rx, input logic [NOBJ-1:0] tx);
    @(negedge clk);
    obj_rx_evt = rx; obj_tx_evt = tx;
    @(negedge clk);
    obj_rx_evt = '0; obj_tx_evt = '0;
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state, R12 registered read
    rd(3'd0, v); chk("R1 ctrl", v, 8'h01);
    chk("R1 init_mode", init_mode, 1);
    rd(3'd6, v); chk("R1 timing", v, 8'h00);
    rd(3'd1, v); chk("R1 status", v, 0);
    rd(3'd3, v); chk("R1 objpend", v, 0);
    rd(3'd2, v); chk("R1 ident", v, 0);
    chk("R1 irq", irq, 0);

    // R2 reserved bits
    wr(3'd0, 8'hFF); rd(3'd0, v); chk("R2 ctrl mask", v, 8'h4F);
    wr(3'd0, 8'h30); rd(3'd0, v); chk("R2 reserved only", v, 8'h00);
    chk("R2 init_mode", init_mode, 0);

    // R3 timing lock
    wr(3'd6, 8'h5A); rd(3'd6, v); chk("R3 locked", v, 8'h00);
    chk("R3 timing_cfg locked", timing_cfg, 8'h00);
    wr(3'd0, 8'h40); wr(3'd6, 8'h5A); rd(3'd6, v); chk("R3 unlocked", v, 8'h5A);
    chk("R3 timing_cfg", timing_cfg, 8'h5A);
    wr(3'd0, 8'h00); wr(3'd6, 8'hA5); rd(3'd6, v); chk("R3 relocked", v, 8'h5A);

    // R4 R5 R9 R11 R6: each source under every enable combination
    for (int m = 0; m < 8; m++) begin
      for (int s = 0; s < 5; s++) begin
        int eie, sie, ie, cls;
        eie = m & 1; sie = (m >> 1) & 1; ie = (m >> 2) & 1;
        cls = (s < 3) ? sie : eie;
        wr(3'd0, 8'((eie << 3) | (sie << 2) | (ie << 1)));
        pulse_src(s);
        rd(3'd2, v);
        chk(s < 3 ? "R5 irq" : "R4 irq", irq, ie & cls);
        chk("R11 ident status", v, cls);
        rd(3'd1, v); chk(s == 0 ? "R6 rx flag" : "R10 flag", v, 1 << s);
        if (s == 0) begin rd(3'd3, v); chk("R6 no object", v, 0); end
        wr(3'd1, 8'h1F);
        @(negedge clk);
        chk("R10 irq after clear", irq, 0);
      end
    end

    // R8 object gating, R9, R11
    wr(3'd0, 8'h02);
    for (int o = 0; o < NOBJ; o++) begin
      for (int e = 0; e < 4; e++) begin
        for (int k = 1; k < 4; k++) begin
          int hit;
          hit = ((k & 1) & (e & 1)) | (((k >> 1) & 1) & ((e >> 1) & 1));
          wr(3'd4, 8'((e & 1) << o));
          wr(3'd5, 8'(((e >> 1) & 1) << o));
          pulse_obj(NOBJ'((k & 1) << o), NOBJ'(((k >> 1) & 1) << o));
          rd(3'd3, v);
          chk("R8 objpend", v, hit << o);
          chk("R9 irq obj", irq, hit);
          rd(3'd2, v);
          chk("R11 ident obj", v, hit ? o + 2 : 0);
          wr(3'd3, 8'hFF);
        end
      end
    end

    // R11 priority over all object patterns, with and without status flag
    wr(3'd4, 8'h0F);
    for (int st = 0; st < 2; st++) begin
      wr(3'd0, 8'h06);
      for (int p = 0; p < 16; p++) begin
        int expid;
        expid = 0;
        for (int b = NOBJ - 1; b >= 0; b--) if ((p >> b) & 1) expid = b + 2;
        if (st == 1) begin pulse_src(1); expid = 1; end
        pulse_obj(NOBJ'(p), '0);
        rd(3'd2, v);
        chk("R11 priority", v, expid);
        chk("R9 irq priority", irq, (expid != 0) ? 1 : 0);
        wr(3'd3, 8'hFF); wr(3'd1, 8'h1F);
      end
    end

    // R7 last-error-code change detection
    wr(3'd1, 8'h1F);
    for (int c = 0; c < 8; c++) begin
      for (int rep = 0; rep < 2; rep++) begin
        @(negedge clk);
        lec_code = 3'(c); lec_upd = 1;
        @(negedge clk);
        lec_upd = 0;
        rd(3'd1, v);
        chk("R7 lec flag", v, (3'(c) != lec_prev) ? 4 : 0);
        lec_prev = 3'(c);
        rd(3'd7, v); chk("R7 lec code", v, c);
        wr(3'd1, 8'h1F);
      end
    end

    // R10 partial clear, zero write, collision
    pulse_src(0); pulse_src(1);
    wr(3'd1, 8'h00); rd(3'd1, v); chk("R10 zero write", v, 8'h03);
    wr(3'd1, 8'h01); rd(3'd1, v); chk("R10 partial", v, 8'h02);
    @(negedge clk);
    reg_wr = 1; reg_addr = 3'd1; reg_wdata = 8'h03; evt_tx_ok = 1;
    @(negedge clk);
    reg_wr = 0; evt_tx_ok = 0;
    rd(3'd1, v); chk("R10 set wins", v, 8'h02);
    wr(3'd1, 8'h1F);
    wr(3'd0, 8'h02); wr(3'd5, 8'h01);
    @(negedge clk);
    reg_wr = 1; reg_addr = 3'd3; reg_wdata = 8'h01; obj_tx_evt = 4'h1;
    @(negedge clk);
    reg_wr = 0; obj_tx_evt = '0;
    rd(3'd3, v); chk("R10 obj set wins", v, 8'h01);
    rd(3'd5, v); chk("R12 read enable", v, 8'h01);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule